// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

The block is a small 32-bit processor that fetches, decodes, executes and retires one instruction in every clock cycle. It runs a nine-instruction subset: register-to-register add, subtract, bitwise and, bitwise or and signed set-less-than, word load, word store, branch-if-equal and unconditional jump. A program counter, a 32-entry register file with two read ports and one write port, and two private word arrays (one for instructions, one for data) are held inside the block.

Control is in two levels. A main decoder looks at the 6-bit opcode and produces the datapath selects and a 2-bit ALU class. A second decoder refines that class with the 6-bit function field when the instruction is register-to-register, giving a 3-bit ALU operation. The next program counter comes from two cascaded selectors: the first picks between the sequential address and the branch target, the second picks between that result and the jump target.

Programs and data are placed in the arrays through a preload stream with a valid/ready handshake. Ready is high only while the core is held in reset, so a word offered while the core runs sees ready low and is not taken. The valid signal may be held for as many cycles as needed; a word is written on each rising edge with valid and ready both high. A debug view shows the current program counter and the register write made in the current cycle.

Top module: `mono_cycle_core`

## Requirements
- R1: While reset is low the program counter reads 0 and every register holds 0; after release the first instruction fetched is at address 0.
- R2: With opcode 0, the function codes 0x20, 0x22, 0x24 and 0x25 write rs+rt, rs-rt, rs&rt and rs|rt (ALU codes 010, 110, 000, 001) into the register named in bits 15:11.
- R3: With opcode 0 and function code 0x2A, the register in bits 15:11 receives 1 when rs is less than rt as signed 32-bit numbers and 0 otherwise (ALU code 111).
- R4: Opcode 35 writes the data word at byte address rs + sign-extended bits 15:0 into the register named in bits 20:16.
- R5: Opcode 43 stores the register in bits 20:16 to the data word at byte address rs + sign-extended bits 15:0 and writes no register.
- R6: Opcode 4 sets the next program counter to PC+4 + (sign-extended bits 15:0 shifted left by 2) when rs equals rt, and to PC+4 otherwise; it writes no register.
- R7: Opcode 2 sets the next program counter to bits 31:28 of PC+4 joined with bits 25:0 of the instruction shifted left by 2; it writes no register.
- R8: A write aimed at register 0 is dropped and register 0 always reads as 0.
- R9: An opcode other than 0, 2, 4, 35, 43, or opcode 0 with a function code outside the five listed, writes neither a register nor memory and advances the program counter by 4.
- R10: The preload port is ready exactly while reset is low; select 0 addresses the instruction array and select 1 the data array, by word index; an offered word while the core runs is not stored.
- R11: The debug write signals show the enable, register number and value of the write that commits at the next rising edge.
- R12: Any instruction that is neither a taken branch nor a jump advances the program counter by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_valid_i | input | 1 | Preload word offered |
| load_ready_o | output | 1 | Preload word accepted this cycle (high during reset) |
| load_sel_i | input | 1 | 0: instruction array, 1: data array |
| load_addr_i | input | LD_AW | Word index into the selected array |
| load_data_i | input | 32 | Word to store |
| dbg_pc_o | output | 32 | Current program counter |
| dbg_wr_en_o | output | 1 | A register write commits at the next edge |
| dbg_wr_addr_o | output | 5 | Register number of that write |
| dbg_wr_data_o | output | 32 | Value of that write |

## Verification
The hardest situation to reach is a branch whose taken path lands backwards on a jump, because the only way to set up equal and unequal operands is to load them from the data array first, and a mistake in either next-address selector shows only as a wrong address several instructions later. The branch program therefore loads two equal values and one different value, runs a not-taken compare, a forward taken compare, a backward taken compare onto a jump, and checks the program counter at every step. A word offered on the preload port while the program runs, followed by a load of the same location, shows that the running core ignores the port.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_JUMP  = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_LOAD  = 6'd35;
  localparam logic [5:0] OP_STORE = 6'd43;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    CLS_ADDR  = 2'b00,
    CLS_CMP   = 2'b01,
    CLS_FUNCT = 2'b10,
    CLS_NONE  = 2'b11
  } alu_cls_e;

  typedef struct packed {
    logic     legal;
    logic     reg_write;
    logic     dst_rd;
    logic     use_imm;
    logic     from_mem;
    logic     mem_write;
    logic     branch;
    logic     jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/mcc_main_dec.sv
module mcc_main_dec
  import mcc_pkg::*;
(
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o         = '0;
    ctrl_o.alu_cls = CLS_NONE;
    unique case (opcode_i)
      OP_RTYPE: begin
        ctrl_o.legal     = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.dst_rd    = 1'b1;
        ctrl_o.alu_cls   = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctrl_o.legal     = 1'b1;
        ctrl_o.reg_write = 1'b1;
        ctrl_o.use_imm   = 1'b1;
        ctrl_o.from_mem  = 1'b1;
        ctrl_o.alu_cls   = CLS_ADDR;
      end
      OP_STORE: begin
        ctrl_o.legal     = 1'b1;
        ctrl_o.use_imm   = 1'b1;
        ctrl_o.mem_write = 1'b1;
        ctrl_o.alu_cls   = CLS_ADDR;
      end
      OP_BEQ: begin
        ctrl_o.legal   = 1'b1;
        ctrl_o.branch  = 1'b1;
        ctrl_o.alu_cls = CLS_CMP;
      end
      OP_JUMP: begin
        ctrl_o.legal = 1'b1;
        ctrl_o.jump  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mcc_alu_ctl.sv
module mcc_alu_ctl
  import mcc_pkg::*;
(
  input  alu_cls_e   cls_i,
  input  logic [5:0] funct_i,
  output alu_fn_e    fn_o,
  output logic       ok_o
);
  always_comb begin
    fn_o = ALU_ADD;
    ok_o = 1'b1;
    unique case (cls_i)
      CLS_ADDR: fn_o = ALU_ADD;
      CLS_CMP:  fn_o = ALU_SUB;
      CLS_FUNCT: begin
        unique case (funct_i)
          FN_ADD:  fn_o = ALU_ADD;
          FN_SUB:  fn_o = ALU_SUB;
          FN_AND:  fn_o = ALU_AND;
          FN_OR:   fn_o = ALU_OR;
          FN_SLT:  fn_o = ALU_SLT;
          default: ok_o = 1'b0;
        endcase
      end
      default: fn_o = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
  import mcc_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_fn_e      fn_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o,
  output logic         zero_o
);
  always_comb begin
    unique case (fn_i)
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_SLT: y_o = {{(W-1){1'b0}}, $signed(a_i) < $signed(b_i)};
      default: y_o = '0;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
  parameter int W     = 32,
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_a_i,
  input  logic [AW-1:0] ra_b_i,
  output logic [W-1:0]  rd_a_o,
  output logic [W-1:0]  rd_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i && (wa_i != '0)) begin
      regs_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

  // R8: register 0 reads as zero after any history of writes
  assert_r0_reads_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ra_a_i == '0) |-> (rd_a_o == '0));

  // R11: a committed write is visible on the next read of that register
  assert_write_visible_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0 && ra_b_i == wa_i) |=> (regs_q[$past(wa_i)] == $past(wd_i)));
endmodule

// File: rtl/mono_cycle_core.sv
module mono_cycle_core
  import mcc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_valid_i,
  output logic             load_ready_o,
  input  logic             load_sel_i,
  input  logic [LD_AW-1:0] load_addr_i,
  input  logic [31:0]      load_data_i,
  output logic [31:0]      dbg_pc_o,
  output logic             dbg_wr_en_o,
  output logic [4:0]       dbg_wr_addr_o,
  output logic [31:0]      dbg_wr_data_o
);
  localparam int IDEPTH = 1 << IMEM_AW;
  localparam int DDEPTH = 1 << DMEM_AW;

  logic [31:0] imem [IDEPTH];
  logic [31:0] dmem [DDEPTH];

  logic [31:0] pc_q, pc_next, pc_plus4, br_tgt, j_tgt, pc_after_br;
  logic [31:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, ld_word, wb_data;
  logic [4:0]  wr_reg;
  logic        alu_zero, fn_ok, take_br, reg_we, mem_we, load_fire;
  ctrl_t       ctrl;
  alu_fn_e     alu_fn;

  assign load_ready_o = !rst_ni;
  assign load_fire    = load_valid_i && load_ready_o;

  // preload (only in reset) and store path share each array
  always_ff @(posedge clk_i) begin
    if (load_fire && !load_sel_i) imem[load_addr_i[IMEM_AW-1:0]] <= load_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (load_fire && load_sel_i)  dmem[load_addr_i[DMEM_AW-1:0]] <= load_data_i;
    else if (mem_we)              dmem[alu_y[DMEM_AW+1:2]]       <= rt_val;
  end

  assign instr = imem[pc_q[IMEM_AW+1:2]];

  mcc_main_dec u_main_dec (
    .opcode_i (instr[31:26]),
    .ctrl_o   (ctrl)
  );

  mcc_alu_ctl u_alu_ctl (
    .cls_i   (ctrl.alu_cls),
    .funct_i (instr[5:0]),
    .fn_o    (alu_fn),
    .ok_o    (fn_ok)
  );

  assign wr_reg  = ctrl.dst_rd ? instr[15:11] : instr[20:16];
  assign reg_we  = ctrl.legal && ctrl.reg_write && fn_ok && (wr_reg != 5'd0);
  assign mem_we  = ctrl.legal && ctrl.mem_write && rst_ni;

  mcc_regfile #(.W(32), .NREGS(32)) u_regfile (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (instr[25:21]),
    .ra_b_i (instr[20:16]),
    .rd_a_o (rs_val),
    .rd_b_o (rt_val),
    .we_i   (reg_we),
    .wa_i   (wr_reg),
    .wd_i   (wb_data)
  );

  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

  mcc_alu #(.W(32)) u_alu (
    .fn_i   (alu_fn),
    .a_i    (rs_val),
    .b_i    (alu_b),
    .y_o    (alu_y),
    .zero_o (alu_zero)
  );

  assign ld_word = dmem[alu_y[DMEM_AW+1:2]];
  assign wb_data = ctrl.from_mem ? ld_word : alu_y;

  // next-address path: two cascaded selectors
  assign pc_plus4    = pc_q + 32'd4;
  assign br_tgt      = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign j_tgt       = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_br     = ctrl.branch && alu_zero;
  assign pc_after_br = take_br ? br_tgt : pc_plus4;
  assign pc_next     = ctrl.jump ? j_tgt : pc_after_br;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign dbg_pc_o      = pc_q;
  assign dbg_wr_en_o   = reg_we;
  assign dbg_wr_addr_o = wr_reg;
  assign dbg_wr_data_o = wb_data;

  // R12: sequential flow advances by one word
  assert_seq_pc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_br && !ctrl.jump) |=> (dbg_pc_o == $past(dbg_pc_o) + 32'd4));

  // R7: jump keeps the top nibble of PC+4 and takes the target field
  assert_jump_tgt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.jump |=> (dbg_pc_o == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00}));

  // R5: a store never writes a register in the same cycle
  assert_store_no_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> !dbg_wr_en_o);

  // R8: no reported write targets register 0
  assert_no_r0_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_wr_en_o |-> (dbg_wr_addr_o != 5'd0));

  // R9: unsupported codes leave registers and memory untouched
  assert_illegal_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.legal || !fn_ok) |-> (!dbg_wr_en_o && !mem_we));

  // R6: branch and jump instructions never write a register
  assert_flow_no_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.branch || ctrl.jump) |-> !dbg_wr_en_o);
endmodule

// File: tb/mono_cycle_core_tb.sv
module mono_cycle_core_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_valid_i = 1'b0;
  logic        load_ready_o;
  logic        load_sel_i = 1'b0;
  logic [5:0]  load_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [31:0] dbg_pc_o;
  logic        dbg_wr_en_o;
  logic [4:0]  dbg_wr_addr_o;
  logic [31:0] dbg_wr_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  mono_cycle_core dut_i (
    .clk_i, .rst_ni, .load_valid_i, .load_ready_o, .load_sel_i,
    .load_addr_i, .load_data_i, .dbg_pc_o, .dbg_wr_en_o,
    .dbg_wr_addr_o, .dbg_wr_data_o
  );

  function automatic logic [31:0] enc_r(input logic [4:0] rs, rt, rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs, rt,
                                        input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(input logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put_word(input bit sel, input int idx, input logic [31:0] d);
    load_valid_i = 1'b1; load_sel_i = sel; load_addr_i = idx[5:0]; load_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    load_valid_i = 1'b0;
  endtask

  // one instruction: sample debug view mid-cycle, then let it commit
  task automatic step(input logic [31:0] epc, input bit ewe, input logic [4:0] ea,
                      input logic [31:0] ed, input string tag);
    check(dbg_pc_o == epc, {tag, " pc"}, dbg_pc_o, epc);
    check(dbg_wr_en_o == ewe, {tag, " wr_en"}, {31'd0, dbg_wr_en_o}, {31'd0, ewe});
    if (ewe) begin
      check(dbg_wr_addr_o == ea, {tag, " wr_addr"}, {27'd0, dbg_wr_addr_o}, {27'd0, ea});
      check(dbg_wr_data_o == ed, {tag, " wr_data"}, dbg_wr_data_o, ed);
    end
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic t_reset_state;
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(dbg_pc_o == 32'd0, "R1 pc in reset", dbg_pc_o, 32'd0);
    check(load_ready_o == 1'b1, "R10 ready in reset", {31'd0, load_ready_o}, 32'd1);
  endtask

  task automatic t_alu_mem;
    logic [31:0] p [18];
    p[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    p[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    p[2]  = enc_i(6'd35, 5'd0, 5'd3, 16'd8);
    p[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'h20);
    p[4]  = enc_r(5'd1, 5'd3, 5'd5, 6'h22);
    p[5]  = enc_r(5'd1, 5'd3, 5'd6, 6'h24);
    p[6]  = enc_r(5'd1, 5'd3, 5'd7, 6'h25);
    p[7]  = enc_r(5'd2, 5'd1, 5'd8, 6'h2A);
    p[8]  = enc_r(5'd1, 5'd2, 5'd9, 6'h2A);
    p[9]  = enc_r(5'd1, 5'd3, 5'd10, 6'h2A);
    p[10] = enc_i(6'd43, 5'd0, 5'd7, 16'd12);
    p[11] = enc_i(6'd35, 5'd0, 5'd11, 16'd12);
    p[12] = enc_i(6'd35, 5'd3, 5'd12, 16'hFFFC);
    p[13] = enc_r(5'd1, 5'd1, 5'd0, 6'h20);
    p[14] = enc_r(5'd0, 5'd1, 5'd13, 6'h20);
    p[15] = enc_i(6'd8, 5'd1, 5'd14, 16'd5);
    p[16] = enc_r(5'd1, 5'd3, 5'd15, 6'h27);
    p[17] = enc_i(6'd35, 5'd0, 5'd15, 16'd12);
    rst_ni = 1'b0;
    for (int i = 0; i < 18; i++) put_word(1'b0, i, p[i]);
    put_word(1'b1, 0, 32'd7);
    put_word(1'b1, 1, 32'hFFFF_FFFD);
    put_word(1'b1, 2, 32'd12);
    put_word(1'b1, 3, 32'd0);
    rst_ni = 1'b1;
    #1;
    check(load_ready_o == 1'b0, "R10 not ready when running", {31'd0, load_ready_o}, 32'd0);
    step(32'd0,  1, 5'd1, 32'd7,          "R4 lw r1");
    step(32'd4,  1, 5'd2, 32'hFFFF_FFFD,  "R4 lw r2");
    step(32'd8,  1, 5'd3, 32'd12,         "R4 lw r3");
    step(32'd12, 1, 5'd4, 32'd4,          "R2 add");
    step(32'd16, 1, 5'd5, 32'hFFFF_FFFB,  "R2 sub");
    step(32'd20, 1, 5'd6, 32'd4,          "R2 and");
    step(32'd24, 1, 5'd7, 32'd15,         "R2 or");
    step(32'd28, 1, 5'd8, 32'd1,          "R3 slt neg<pos");
    step(32'd32, 1, 5'd9, 32'd0,          "R3 slt pos<neg");
    step(32'd36, 1, 5'd10, 32'd1,         "R3 slt 7<12");
    step(32'd40, 0, 5'd0, 32'd0,          "R5 sw no reg write");
    step(32'd44, 1, 5'd11, 32'd15,        "R5 sw data readback");
    step(32'd48, 1, 5'd12, 32'd12,        "R4 negative offset");
    step(32'd52, 0, 5'd0, 32'd0,          "R8 write to r0 dropped");
    step(32'd56, 1, 5'd13, 32'd7,         "R8 r0 reads zero");
    step(32'd60, 0, 5'd0, 32'd0,          "R9 unknown opcode");
    load_valid_i = 1'b1; load_sel_i = 1'b1; load_addr_i = 6'd3; load_data_i = 32'hDEAD_BEEF;
    step(32'd64, 0, 5'd0, 32'd0,          "R9 unknown funct");
    load_valid_i = 1'b0;
    step(32'd68, 1, 5'd15, 32'd15,        "R10 preload ignored while running");
    check(dbg_pc_o == 32'd72, "R12 pc after sequence", dbg_pc_o, 32'd72);
  endtask

  task automatic t_branch_jump;
    logic [31:0] p [11];
    p[0]  = enc_r(5'd4, 5'd7, 5'd5, 6'h20);
    p[1]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    p[2]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    p[3]  = enc_i(6'd35, 5'd0, 5'd3, 16'd8);
    p[4]  = enc_i(6'd4, 5'd1, 5'd3, 16'd5);
    p[5]  = enc_i(6'd4, 5'd1, 5'd2, 16'd2);
    p[6]  = enc_j(26'd10);
    p[7]  = enc_r(5'd1, 5'd1, 5'd20, 6'h20);
    p[8]  = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFD);
    p[9]  = enc_r(5'd1, 5'd1, 5'd21, 6'h20);
    p[10] = enc_r(5'd1, 5'd3, 5'd6, 6'h20);
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 11; i++) put_word(1'b0, i, p[i]);
    put_word(1'b1, 0, 32'd5);
    put_word(1'b1, 1, 32'd5);
    put_word(1'b1, 2, 32'd9);
    rst_ni = 1'b1;
    step(32'd0,  1, 5'd5, 32'd0,  "R1 registers cleared by reset");
    step(32'd4,  1, 5'd1, 32'd5,  "R4 lw r1");
    step(32'd8,  1, 5'd2, 32'd5,  "R4 lw r2");
    step(32'd12, 1, 5'd3, 32'd9,  "R4 lw r3");
    step(32'd16, 0, 5'd0, 32'd0,  "R6 beq not taken");
    step(32'd20, 0, 5'd0, 32'd0,  "R6 beq forward taken");
    step(32'd32, 0, 5'd0, 32'd0,  "R6 beq backward taken");
    step(32'd24, 0, 5'd0, 32'd0,  "R7 jump");
    step(32'd40, 1, 5'd6, 32'd14, "R7 jump target reached");
  endtask

  initial begin
    t_reset_state();
    t_alu_mem();
    t_branch_jump();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule